// File: doc/BRIEF.md
# Trap Return State Restorer

This block carries out the two ways of leaving a trap handler: return-and-skip (DONE) and return-and-reexecute (RETRY). When an operation is requested, the block reads the trap record for the current trap level from its inputs. That record holds a saved PC, a saved next PC and a 40-bit packed state word. From it the block rebuilds the program counters, the condition codes, the address space identifier, the processor state and the register window pointer, and it lowers the trap level by one.

The trap-level stack itself lives outside the block. Its selected entry and the current trap level and processor state are driven in as plain inputs. When the restored processor state selects a different bank of global registers than the current one, the block raises a one-cycle bank-switch strobe and presents the new bank code. A request made at trap level 0 is refused: a one-cycle illegal strobe is raised and nothing else changes.

All restored values are registered. They change together on the clock edge that samples the request, and the completion strobe is high in the same cycle.

Top module: `trap_return_unit`

## Requirements
- R1: A DONE request (op_retry_i = 0) at a nonzero trap level sets pc_o to saved_npc_i and npc_o to saved_npc_i + 4, wrapping at the PC width.
- R2: A RETRY request (op_retry_i = 1) at a nonzero trap level sets pc_o to saved_pc_i and npc_o to saved_npc_i.
- R3: An accepted request loads ccr_o from saved_state_i[39:32] and asi_o from saved_state_i[31:24].
- R4: An accepted request loads pstate_o from saved_state_i[19:8] ANDed with 12'hF3F.
- R5: An accepted request loads cwp_o with NWIN-1-(saved_state_i[7:0] mod NWIN), so cwp_o is always below NWIN.
- R6: gbank_o shows the bank that the restored state selects through its bits 11, 10 and 0: 12'h000 gives 0 (normal), 12'h001 gives 1 (alternate), 12'h400 gives 2 (MMU), 12'h800 gives 3 (interrupt), and any other combination gives 0. gbank_switch_o pulses only on an accepted request whose restored state differs from cur_pstate_i under mask 12'hC01.
- R7: When HAS_GL is 1, bit 0 of the restored state is cleared before the bank is chosen and before it is stored in pstate_o.
- R8: An accepted request sets tl_o to cur_tl_i - 1. All outputs update on the first rising edge after the request is sampled, and done_o is high for exactly that cycle.
- R9: A request with cur_tl_i = 0 raises illegal_o for one cycle. It does not raise done_o or gbank_switch_o and leaves every restored output unchanged.
- R10: After reset, every restored output is 0 and done_o, illegal_o and gbank_switch_o are low.
- R11: While op_valid_i is low, all restored outputs keep their values and the strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Request a trap return this cycle |
| op_retry_i | input | 1 | 1 = RETRY, 0 = DONE |
| cur_tl_i | input | TL_W | Current trap level |
| cur_pstate_i | input | 12 | Current processor state, used for bank comparison |
| saved_pc_i | input | PC_W | Saved PC of the current trap record |
| saved_npc_i | input | PC_W | Saved next PC of the current trap record |
| saved_state_i | input | 40 | Packed saved state word |
| pc_o | output | PC_W | Restored PC |
| npc_o | output | PC_W | Restored next PC |
| ccr_o | output | 8 | Restored condition codes |
| asi_o | output | 8 | Restored address space identifier |
| pstate_o | output | 12 | Restored processor state |
| cwp_o | output | CWP_W | Restored window pointer (internal numbering) |
| tl_o | output | TL_W | New trap level |
| gbank_o | output | 2 | Selected global register bank |
| gbank_switch_o | output | 1 | One-cycle pulse: global bank changed |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | One-cycle pulse: request refused at trap level 0 |

## Verification
Every result of a request is due exactly one rising edge after the request is sampled. The restored fields, the new trap level and the three strobes all land together in that cycle. The bench drives requests on the falling edge, holds them across one rising edge, and samples all outputs 2 ns after that edge. Before the next request it drops op_valid_i and checks again a few cycles later, which confirms that the strobes lasted a single cycle and that idle cycles and refused requests left the restored state alone.

// File: rtl/trap_return_pkg.sv
package trap_return_pkg;

  localparam int STATE_W   = 40;
  localparam int CCR_LSB   = 32;
  localparam int ASI_LSB   = 24;
  localparam int PST_LSB   = 8;
  localparam int PST_W     = 12;
  localparam int CWPF_W    = 8;
  localparam int AG_BIT    = 0;
  localparam int MG_BIT    = 10;
  localparam int IG_BIT    = 11;

  localparam logic [PST_W-1:0] PST_KEEP  = 12'hF3F;
  localparam logic [PST_W-1:0] BANK_MASK = 12'hC01;

  typedef enum logic [1:0] {
    GB_NORMAL = 2'd0,
    GB_ALT    = 2'd1,
    GB_MMU    = 2'd2,
    GB_INTR   = 2'd3
  } gbank_e;

endpackage

// File: rtl/trr_pc_select.sv
module trr_pc_select #(
  parameter int PC_W = 64
) (
  input  logic            retry_i,
  input  logic [PC_W-1:0] tpc_i,
  input  logic [PC_W-1:0] tnpc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);

  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  always_comb begin
    if (retry_i) begin
      // re-execute the trapped instruction
      pc_o  = tpc_i;
      npc_o = tnpc_i;
    end else begin
      // skip the trapped instruction
      pc_o  = tnpc_i;
      npc_o = tnpc_i + INSN_BYTES;
    end
  end

endmodule

// File: rtl/trr_field_unpack.sv
module trr_field_unpack
  import trap_return_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter bit HAS_GL = 1'b0,
  parameter int CWP_W  = $clog2(NWIN)
) (
  input  logic [STATE_W-1:0] state_i,
  output logic [7:0]         ccr_o,
  output logic [7:0]         asi_o,
  output logic [PST_W-1:0]   pstate_o,
  output logic [CWP_W-1:0]   cwp_o
);

  logic [CWPF_W-1:0] cwp_field;
  logic [PST_W-1:0]  pst_raw;
  int unsigned       cwp_mod;

  always_comb begin
    ccr_o     = state_i[CCR_LSB +: 8];
    asi_o     = state_i[ASI_LSB +: 8];
    pst_raw   = state_i[PST_LSB +: PST_W] & PST_KEEP;
    if (HAS_GL) begin
      pst_raw[AG_BIT] = 1'b0;
    end
    pstate_o  = pst_raw;
    cwp_field = state_i[CWPF_W-1:0];
    cwp_mod   = 32'(cwp_field) % NWIN;
    cwp_o     = CWP_W'(32'(NWIN - 1) - cwp_mod);
  end

endmodule

// File: rtl/trr_gbank_sel.sv
module trr_gbank_sel
  import trap_return_pkg::*;
(
  input  logic [PST_W-1:0] new_pstate_i,
  input  logic [PST_W-1:0] cur_pstate_i,
  output logic [1:0]       bank_o,
  output logic             differ_o
);

  logic [PST_W-1:0] new_sel;
  logic [PST_W-1:0] cur_sel;
  gbank_e           bank;

  always_comb begin
    new_sel  = new_pstate_i & BANK_MASK;
    cur_sel  = cur_pstate_i & BANK_MASK;
    differ_o = (new_sel != cur_sel);
    unique case (new_sel)
      12'h001: bank = GB_ALT;
      12'h400: bank = GB_MMU;
      12'h800: bank = GB_INTR;
      default: bank = GB_NORMAL;
    endcase
    bank_o = bank;
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_return_pkg::*;
#(
  parameter int PC_W   = 64,
  parameter int NWIN   = 8,
  parameter int TL_W   = 3,
  parameter bit HAS_GL = 1'b0,
  localparam int CWP_W = $clog2(NWIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid_i,
  input  logic               op_retry_i,
  input  logic [TL_W-1:0]    cur_tl_i,
  input  logic [11:0]        cur_pstate_i,
  input  logic [PC_W-1:0]    saved_pc_i,
  input  logic [PC_W-1:0]    saved_npc_i,
  input  logic [39:0]        saved_state_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    npc_o,
  output logic [7:0]         ccr_o,
  output logic [7:0]         asi_o,
  output logic [11:0]        pstate_o,
  output logic [CWP_W-1:0]   cwp_o,
  output logic [TL_W-1:0]    tl_o,
  output logic [1:0]         gbank_o,
  output logic               gbank_switch_o,
  output logic               done_o,
  output logic               illegal_o
);

  localparam logic [TL_W-1:0] TL_ONE = TL_W'(1);

  // combinational pieces
  logic [PC_W-1:0]  pc_n, npc_n;
  logic [7:0]       ccr_n, asi_n;
  logic [PST_W-1:0] pst_n;
  logic [CWP_W-1:0] cwp_n;
  logic [1:0]       bank_n;
  logic             bank_differ;

  // next state
  logic             accept, reject, upd_en;
  logic [TL_W-1:0]  tl_n;

  // registers
  logic [PC_W-1:0]  pc_q, npc_q;
  logic [7:0]       ccr_q, asi_q;
  logic [PST_W-1:0] pst_q;
  logic [CWP_W-1:0] cwp_q;
  logic [TL_W-1:0]  tl_q;
  logic [1:0]       bank_q;
  logic             switch_q, done_q, illegal_q;

  trr_pc_select #(
    .PC_W (PC_W)
  ) u_pc_select (
    .retry_i (op_retry_i),
    .tpc_i   (saved_pc_i),
    .tnpc_i  (saved_npc_i),
    .pc_o    (pc_n),
    .npc_o   (npc_n)
  );

  trr_field_unpack #(
    .NWIN   (NWIN),
    .HAS_GL (HAS_GL),
    .CWP_W  (CWP_W)
  ) u_field_unpack (
    .state_i  (saved_state_i),
    .ccr_o    (ccr_n),
    .asi_o    (asi_n),
    .pstate_o (pst_n),
    .cwp_o    (cwp_n)
  );

  trr_gbank_sel u_gbank_sel (
    .new_pstate_i (pst_n),
    .cur_pstate_i (cur_pstate_i),
    .bank_o       (bank_n),
    .differ_o     (bank_differ)
  );

  always_comb begin
    accept = op_valid_i && (cur_tl_i != '0);
    reject = op_valid_i && (cur_tl_i == '0);
    upd_en = accept;
    tl_n   = cur_tl_i - TL_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      npc_q     <= '0;
      ccr_q     <= '0;
      asi_q     <= '0;
      pst_q     <= '0;
      cwp_q     <= '0;
      tl_q      <= '0;
      bank_q    <= '0;
      switch_q  <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (upd_en) begin
        pc_q   <= pc_n;
        npc_q  <= npc_n;
        ccr_q  <= ccr_n;
        asi_q  <= asi_n;
        pst_q  <= pst_n;
        cwp_q  <= cwp_n;
        tl_q   <= tl_n;
        bank_q <= bank_n;
      end
      switch_q  <= accept && bank_differ;
      done_q    <= accept;
      illegal_q <= reject;
    end
  end

  assign pc_o           = pc_q;
  assign npc_o          = npc_q;
  assign ccr_o          = ccr_q;
  assign asi_o          = asi_q;
  assign pstate_o       = pst_q;
  assign cwp_o          = cwp_q;
  assign tl_o           = tl_q;
  assign gbank_o        = bank_q;
  assign gbank_switch_o = switch_q;
  assign done_o         = done_q;
  assign illegal_o      = illegal_q;

  // checks next to the registers they guard
  AST_DONE_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(op_retry_i)) |-> (npc_o == $past(saved_npc_i) + PC_W'(4))); // R1
  AST_RETRY_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(op_retry_i)) |-> (pc_o == $past(saved_pc_i))); // R2
  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cwp_o) < NWIN)); // R5
  AST_SWITCH_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    gbank_switch_o |-> done_o); // R6
  AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tl_o == $past(cur_tl_i) - TL_ONE)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && illegal_o)); // R9
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($stable(pc_o) && $stable(tl_o) && $stable(pstate_o) && $stable(cwp_o))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(npc_o) && $stable(ccr_o) && $stable(gbank_o))); // R11

  generate
    if (HAS_GL) begin : g_gl_check
      AST_GL_NO_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        !pstate_o[AG_BIT]); // R7
    end
  endgenerate

endmodule

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;

  localparam int PC_W  = 64;
  localparam int TL_W  = 3;
  localparam int NW_A  = 8;
  localparam int NW_B  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            op_valid, op_retry;
  logic [TL_W-1:0] cur_tl;
  logic [11:0]     cur_pst;
  logic [PC_W-1:0] s_pc, s_npc;
  logic [39:0]     s_state;

  logic [PC_W-1:0] a_pc, a_npc, b_pc, b_npc;
  logic [7:0]      a_ccr, a_asi, b_ccr, b_asi;
  logic [11:0]     a_pst, b_pst;
  logic [2:0]      a_cwp, b_cwp;
  logic [TL_W-1:0] a_tl, b_tl;
  logic [1:0]      a_bank, b_bank;
  logic            a_sw, a_done, a_ill, b_sw, b_done, b_ill;

  trap_return_unit #(.PC_W(PC_W), .NWIN(NW_A), .TL_W(TL_W), .HAS_GL(1'b0)) u_trap_return_unit (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_retry_i(op_retry),
    .cur_tl_i(cur_tl), .cur_pstate_i(cur_pst), .saved_pc_i(s_pc), .saved_npc_i(s_npc),
    .saved_state_i(s_state), .pc_o(a_pc), .npc_o(a_npc), .ccr_o(a_ccr), .asi_o(a_asi),
    .pstate_o(a_pst), .cwp_o(a_cwp), .tl_o(a_tl), .gbank_o(a_bank),
    .gbank_switch_o(a_sw), .done_o(a_done), .illegal_o(a_ill));

  trap_return_unit #(.PC_W(PC_W), .NWIN(NW_B), .TL_W(TL_W), .HAS_GL(1'b1)) u_trap_return_unit_gl (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_retry_i(op_retry),
    .cur_tl_i(cur_tl), .cur_pstate_i(cur_pst), .saved_pc_i(s_pc), .saved_npc_i(s_npc),
    .saved_state_i(s_state), .pc_o(b_pc), .npc_o(b_npc), .ccr_o(b_ccr), .asi_o(b_asi),
    .pstate_o(b_pst), .cwp_o(b_cwp), .tl_o(b_tl), .gbank_o(b_bank),
    .gbank_switch_o(b_sw), .done_o(b_done), .illegal_o(b_ill));

  int checks = 0;
  int failures = 0;

  // expected state per instance: index 0 = plain, 1 = with GL
  logic [PC_W-1:0] e_pc[2], e_npc[2];
  logic [7:0]      e_ccr[2], e_asi[2];
  logic [11:0]     e_pst[2];
  logic [2:0]      e_cwp[2];
  logic [TL_W-1:0] e_tl[2];
  logic [1:0]      e_bank[2];
  logic            e_sw[2], e_done, e_ill;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] f_pst(input logic [39:0] st, input bit gl);
    logic [11:0] p;
    p = st[19:8] & 12'hF3F;
    if (gl) p[0] = 1'b0;
    return p;
  endfunction

  function automatic logic [1:0] f_bank(input logic [11:0] p);
    case (p & 12'hC01)
      12'h001: return 2'd1;
      12'h400: return 2'd2;
      12'h800: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] f_cwp(input logic [39:0] st, input int nw);
    return 3'(nw - 1 - (int'(st[7:0]) % nw));
  endfunction

  task automatic model_apply();
    e_done = op_valid && (cur_tl != 0);
    e_ill  = op_valid && (cur_tl == 0);
    for (int i = 0; i < 2; i++) begin
      e_sw[i] = 1'b0;
      if (e_done) begin
        logic [11:0] p;
        p = f_pst(s_state, i == 1);
        e_pc[i]   = op_retry ? s_pc : s_npc;
        e_npc[i]  = op_retry ? s_npc : s_npc + 64'd4;
        e_ccr[i]  = s_state[39:32];
        e_asi[i]  = s_state[31:24];
        e_pst[i]  = p;
        e_cwp[i]  = f_cwp(s_state, (i == 1) ? NW_B : NW_A);
        e_tl[i]   = cur_tl - 1'b1;
        e_bank[i] = f_bank(p);
        e_sw[i]   = ((p & 12'hC01) != (cur_pst & 12'hC01));
      end
    end
  endtask

  task automatic compare_all(input string tag);
    chk("R8", {tag, " done"}, 64'(a_done), 64'(e_done));
    chk("R9", {tag, " illegal"}, 64'(a_ill), 64'(e_ill));
    chk("R8", {tag, " done gl"}, 64'(b_done), 64'(e_done));
    chk("R1/R2", {tag, " pc"}, a_pc, e_pc[0]);
    chk("R1/R2", {tag, " npc"}, a_npc, e_npc[0]);
    chk("R3", {tag, " ccr"}, 64'(a_ccr), 64'(e_ccr[0]));
    chk("R3", {tag, " asi"}, 64'(a_asi), 64'(e_asi[0]));
    chk("R4", {tag, " pstate"}, 64'(a_pst), 64'(e_pst[0]));
    chk("R5", {tag, " cwp"}, 64'(a_cwp), 64'(e_cwp[0]));
    chk("R8", {tag, " tl"}, 64'(a_tl), 64'(e_tl[0]));
    chk("R6", {tag, " bank"}, 64'(a_bank), 64'(e_bank[0]));
    chk("R6", {tag, " switch"}, 64'(a_sw), 64'(e_sw[0]));
    chk("R7", {tag, " pstate gl"}, 64'(b_pst), 64'(e_pst[1]));
    chk("R5", {tag, " cwp gl"}, 64'(b_cwp), 64'(e_cwp[1]));
    chk("R7", {tag, " bank gl"}, 64'(b_bank), 64'(e_bank[1]));
    chk("R7", {tag, " switch gl"}, 64'(b_sw), 64'(e_sw[1]));
    chk("R2", {tag, " npc gl"}, b_npc, e_npc[1]);
  endtask

  task automatic run_op(input string tag, input bit retry, input logic [TL_W-1:0] tl,
                        input logic [11:0] cp, input logic [PC_W-1:0] pc,
                        input logic [PC_W-1:0] npc, input logic [39:0] st);
    @(negedge clk);
    op_valid = 1'b1; op_retry = retry; cur_tl = tl; cur_pst = cp;
    s_pc = pc; s_npc = npc; s_state = st;
    model_apply();
    @(posedge clk); #2;
    compare_all(tag);
    @(negedge clk);
    op_valid = 1'b0;
    s_pc = ~s_pc; s_npc = ~s_npc; s_state = ~s_state; cur_tl = 3'd5;
    e_done = 1'b0; e_ill = 1'b0; e_sw[0] = 1'b0; e_sw[1] = 1'b0;
    repeat (2) @(posedge clk); #2;
    compare_all({tag, " idle R11"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed = 32'h5EED_1234;
    void'($urandom(seed));
    op_valid = 1'b0; op_retry = 1'b0; cur_tl = '0; cur_pst = '0;
    s_pc = '0; s_npc = '0; s_state = '0;
    for (int i = 0; i < 2; i++) begin
      e_pc[i] = '0; e_npc[i] = '0; e_ccr[i] = '0; e_asi[i] = '0; e_pst[i] = '0;
      e_cwp[i] = '0; e_tl[i] = '0; e_bank[i] = '0; e_sw[i] = 1'b0;
    end
    e_done = 1'b0; e_ill = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    compare_all("reset R10");
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;
    compare_all("post-reset R10");

    // R1 DONE with next-PC wrap
    run_op("R1 done wrap", 1'b0, 3'd3, 12'h000, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF,
           40'hA5_3C_0F_1F_FF);
    // R2 RETRY, MMU bank selected (R6 switch)
    run_op("R2 retry mmu", 1'b1, 3'd1, 12'h000, 64'h2000, 64'h2004, 40'h12_34_04_00_03);
    // R6 same bank under mask, other bits differ: no switch
    run_op("R6 nochange", 1'b0, 3'd7, 12'h4F0, 64'h0, 64'h80, 40'h00_00_04_3E_00);
    // R6 illegal combination -> normal bank; R7 AG cleared in GL instance
    run_op("R6 combo", 1'b1, 3'd2, 12'h000, 64'h40, 64'h44, 40'h01_02_08_01_07);
    // R7 alternate bank only in plain instance
    run_op("R7 ag", 1'b0, 3'd4, 12'h000, 64'h50, 64'h54, 40'h00_00_00_01_0C);
    // R4 masking of bits 6 and 7
    run_op("R4 mask", 1'b1, 3'd6, 12'h800, 64'h60, 64'h64, 40'h00_00_0F_FF_05);
    // R9 refuse at trap level 0
    run_op("R9 tl0", 1'b0, 3'd0, 12'h000, 64'hDEAD, 64'hBEEF, 40'hFF_FF_FF_FF_FF);
    // R5 maximum window field
    run_op("R5 cwpmax", 1'b1, 3'd1, 12'h000, 64'h70, 64'h74, 40'h00_00_00_00_FF);

    for (int n = 0; n < 300; n++) begin
      logic [39:0] st;
      logic [11:0] cp;
      st = {8'($urandom), 32'($urandom)};
      cp = 12'($urandom) & 12'hF3F;
      if (($urandom % 3) == 0) st[19:8] = {($urandom % 2) == 0, ($urandom % 2) == 0, 9'd0, ($urandom % 2) == 0};
      run_op("rand", 1'($urandom), 3'($urandom), cp,
             {32'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)}, st);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule